// File: doc/BRIEF.md
# Diagnostic Tap Selector with Divider Bypass

This block drives one diagnostic pin from one of eight internal sources, picked by a 3-bit tap code. The sources are the serial scan bit, two constant levels, the reference clock divided by sixteen, the pulse train of a programmable 9-bit feedback counter, the divided main clock, and that main clock divided by four. One code puts the block into divider bypass. The slow serial programming clock then replaces the reference as the clock of the feedback counter, and a registered flag tells the surrounding post-divider logic to take its clock from the same serial clock.

All logic runs on one fast sampling clock. The reference, serial and main clocks arrive as sampled levels, and the block works on their rising edges. Every tap goes through one output register, so the pin changes only on the sampling clock.

Top module: `diag_tap_mux`

## Requirements
- R1: When synchronous reset is released, `test_out` and `bypass` are 0, and all dividers and counters restart from zero.
- R2: Tap code 3'b000 copies `scan_bit` to `test_out` one sampling-clock cycle later.
- R3: Tap code 3'b001 drives `test_out` high, and tap code 3'b101 drives it low, one cycle after the code is applied.
- R4: Tap code 3'b010 shows a square wave that toggles on every 8th rising edge of `ref_clk`. The first high level follows the 8th edge after reset.
- R5: Tap code 3'b011 shows the feedback counter. It gives a one-cycle high pulse on every M-th rising edge of `ref_clk`, with M taken from `m_div`. An M of 0 or 1 gives a pulse on every edge.
- R6: Tap code 3'b100 copies the `main_clk` level to `test_out` one cycle later.
- R7: Tap code 3'b111 shows `main_clk` divided by four. It toggles on every 2nd rising edge, and the first high level follows the 2nd edge after reset.
- R8: `bypass` is 1 exactly one cycle after the tap code is 3'b110, and 0 one cycle after any other code.
- R9: While bypass is active, the feedback counter advances on `ser_clk` rising edges after a prescaler set by `n_code` (3'b11 gives 1, 2'b00 gives 2, 2'b01 gives 4, 2'b10 gives 8). Its pulses appear on `test_out`, and `ref_clk` edges do not advance it.
- R10: Outside bypass, `ser_clk` edges do not advance the feedback counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| tsel | input | 3 | Tap code |
| m_div | input | 9 | Feedback counter divide value |
| n_code | input | 2 | Post-divider code, sets the prescale in bypass |
| ref_clk | input | 1 | Reference clock level |
| ser_clk | input | 1 | Serial programming clock level |
| main_clk | input | 1 | Divided main output level |
| scan_bit | input | 1 | Serial shift register output bit |
| test_out | output | 1 | Diagnostic pin |
| bypass | output | 1 | Registered bypass indication |

## Verification
The assertions assume that every sampled clock input stays high or low for at least one sampling cycle between rising edges. Under that assumption no two edge ticks are adjacent, and feedback-counter pulses never merge. They also assume that the level inputs are low while reset is asserted. The stimulus holds each level for a full cycle on each side of an edge, changes inputs only on the falling sampling edge, and keeps all clock inputs low during reset.

// File: rtl/diag_pkg.sv
`timescale 1ns/1ps
package diag_pkg;

    typedef enum logic [2:0] {
        TAP_SCAN   = 3'b000,
        TAP_ONE    = 3'b001,
        TAP_REF16  = 3'b010,
        TAP_MCNT   = 3'b011,
        TAP_MAIN   = 3'b100,
        TAP_ZERO   = 3'b101,
        TAP_BYPASS = 3'b110,
        TAP_MAIN4  = 3'b111
    } tap_e;

    // lane positions of the edge detector
    localparam int LANE_REF  = 0;
    localparam int LANE_SER  = 1;
    localparam int LANE_MAIN = 2;
    localparam int LANES     = 3;

    // prescale limit (ratio - 1) for the post-divider code
    function automatic logic [2:0] prescale_lim(input logic [1:0] code);
        case (code)
            2'b11:   return 3'd0;
            2'b00:   return 3'd1;
            2'b01:   return 3'd3;
            default: return 3'd7;
        endcase
    endfunction

endpackage

// File: rtl/edge_rise.sv
`timescale 1ns/1ps
module edge_rise #(
    parameter int LANES = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] lvl,
    output logic [LANES-1:0] rise
);
    logic [LANES-1:0] prev_q;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) prev_q[i] <= 1'b0;
            else     prev_q[i] <= lvl[i];
        end
        assign rise[i] = lvl[i] & ~prev_q[i];
    end
endmodule

// File: rtl/tick_counter.sv
`timescale 1ns/1ps
module tick_counter #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         fire
);
    logic [W-1:0] cnt_q;

    assign fire = tick && (cnt_q >= limit);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (fire) cnt_q <= '0;
        else if (tick) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/diag_tap_mux.sv
`timescale 1ns/1ps
module diag_tap_mux
    import diag_pkg::*;
#(
    parameter int M_W      = 9,
    parameter int REF_DIV  = 16,
    parameter int MAIN_DIV = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [2:0]     tsel,
    input  logic [M_W-1:0] m_div,
    input  logic [1:0]     n_code,
    input  logic           ref_clk,
    input  logic           ser_clk,
    input  logic           main_clk,
    input  logic           scan_bit,
    output logic           test_out,
    output logic           bypass
);
    localparam int REF_HALF  = REF_DIV / 2;
    localparam int MAIN_HALF = MAIN_DIV / 2;
    localparam int REF_CW    = (REF_HALF > 2) ? $clog2(REF_HALF) : 1;
    localparam int MAIN_CW   = (MAIN_HALF > 2) ? $clog2(MAIN_HALF) : 1;
    localparam logic [REF_CW-1:0]  REF_LIM  = REF_CW'(REF_HALF - 1);
    localparam logic [MAIN_CW-1:0] MAIN_LIM = MAIN_CW'(MAIN_HALF - 1);

    logic [LANES-1:0] lvl, rise;
    logic bypass_q, test_q, m_pulse_q, ref16_q, main4_q;
    logic ref_fire, main_fire, pre_fire, m_fire, m_tick;
    logic [M_W-1:0] m_lim;

    assign lvl[LANE_REF]  = ref_clk;
    assign lvl[LANE_SER]  = ser_clk;
    assign lvl[LANE_MAIN] = main_clk;

    edge_rise #(.LANES(LANES)) u_edges (
        .clk(clk), .rst(rst), .lvl(lvl), .rise(rise)
    );

    // fixed reference and main-clock dividers
    tick_counter #(.W(REF_CW)) u_ref_div (
        .clk(clk), .rst(rst), .tick(rise[LANE_REF]), .limit(REF_LIM), .fire(ref_fire)
    );
    tick_counter #(.W(MAIN_CW)) u_main_div (
        .clk(clk), .rst(rst), .tick(rise[LANE_MAIN]), .limit(MAIN_LIM), .fire(main_fire)
    );

    // bypass prescaler on the serial clock
    tick_counter #(.W(3)) u_prescale (
        .clk(clk), .rst(rst), .tick(rise[LANE_SER] & bypass_q),
        .limit(prescale_lim(n_code)), .fire(pre_fire)
    );

    // feedback counter: source switches with the bypass flag
    assign m_tick = bypass_q ? pre_fire : rise[LANE_REF];
    assign m_lim  = (m_div <= M_W'(1)) ? '0 : m_div - 1'b1;

    tick_counter #(.W(M_W)) u_mcnt (
        .clk(clk), .rst(rst), .tick(m_tick), .limit(m_lim), .fire(m_fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bypass_q  <= 1'b0;
            m_pulse_q <= 1'b0;
            ref16_q   <= 1'b0;
            main4_q   <= 1'b0;
        end else begin
            bypass_q  <= (tsel == TAP_BYPASS);
            m_pulse_q <= m_fire;
            if (ref_fire)  ref16_q <= ~ref16_q;
            if (main_fire) main4_q <= ~main4_q;
        end
    end

    logic tap_val;
    always_comb begin
        case (tap_e'(tsel))
            TAP_SCAN:   tap_val = scan_bit;
            TAP_ONE:    tap_val = 1'b1;
            TAP_REF16:  tap_val = ref16_q;
            TAP_MCNT:   tap_val = m_pulse_q;
            TAP_MAIN:   tap_val = main_clk;
            TAP_ZERO:   tap_val = 1'b0;
            TAP_BYPASS: tap_val = m_pulse_q;
            default:    tap_val = main4_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) test_q <= 1'b0;
        else     test_q <= tap_val;
    end

    assign test_out = test_q;
    assign bypass   = bypass_q;

    // R8
    bypass_set_chk: assert property (@(posedge clk) disable iff (rst)
        (tsel == TAP_BYPASS) |=> bypass_q);
    // R8
    bypass_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (tsel != TAP_BYPASS) |=> !bypass_q);
    // R3
    one_lvl_chk: assert property (@(posedge clk) disable iff (rst)
        (tsel == TAP_ONE) |=> test_q);
    // R3
    zero_lvl_chk: assert property (@(posedge clk) disable iff (rst)
        (tsel == TAP_ZERO) |=> !test_q);
    // R2
    scan_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (tsel == TAP_SCAN) |=> (test_q == $past(scan_bit)));
    // R4
    ref16_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rise[LANE_REF] |=> $stable(ref16_q));
    // R5
    mpulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        m_pulse_q |=> !m_pulse_q);
    // R10
    ser_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!bypass_q && !rise[LANE_REF]) |=> !m_pulse_q);
endmodule

// File: tb/diag_tap_mux_bench.sv
`timescale 1ns/1ps
module diag_tap_mux_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] tsel = 3'b000;
    logic [8:0] m_div = 9'd0;
    logic [1:0] n_code = 2'b11;
    logic       ref_clk = 1'b0, ser_clk = 1'b0, main_clk = 1'b0, scan_bit = 1'b0;
    logic       test_out, bypass;

    int checks = 0;
    int fails  = 0;
    int hi_cnt = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    diag_tap_mux u_diag_tap_mux (
        .clk(clk), .rst(rst), .tsel(tsel), .m_div(m_div), .n_code(n_code),
        .ref_clk(ref_clk), .ser_clk(ser_clk), .main_clk(main_clk),
        .scan_bit(scan_bit), .test_out(test_out), .bypass(bypass)
    );

    always @(negedge clk) if (test_out === 1'b1) hi_cnt++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ref_clk = 0; ser_clk = 0; main_clk = 0; scan_bit = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // which: 0 ref, 1 serial, 2 main
    task automatic one_edge(input int which);
        @(negedge clk);
        case (which)
            0: ref_clk = 1'b1;
            1: ser_clk = 1'b1;
            default: main_clk = 1'b1;
        endcase
        @(negedge clk);
        ref_clk = 1'b0; ser_clk = 1'b0; main_clk = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic count_pulses(input int which, input int n, output int got);
        int s;
        @(posedge clk); s = hi_cnt;
        for (int i = 0; i < n; i++) one_edge(which);
        repeat (3) @(negedge clk);
        @(posedge clk); got = hi_cnt - s;
    endtask

    task automatic t_reset();
        tsel = 3'b011;
        do_reset();
        chk("R1 test_out after reset", test_out, 0);
        chk("R1 bypass after reset", bypass, 0);
    endtask

    task automatic t_levels();
        tsel = 3'b001; repeat (2) @(negedge clk);
        chk("R3 code 001 high", test_out, 1);
        tsel = 3'b101; @(negedge clk);
        chk("R3 code 101 low", test_out, 0);
    endtask

    task automatic t_scan();
        tsel = 3'b000; scan_bit = 1'b0; repeat (2) @(negedge clk);
        scan_bit = 1'b1; @(negedge clk);
        chk("R2 scan high after one cycle", test_out, 1);
        scan_bit = 1'b0; @(negedge clk);
        chk("R2 scan low after one cycle", test_out, 0);
    endtask

    task automatic t_main();
        tsel = 3'b100; @(negedge clk);
        main_clk = 1'b1; @(negedge clk);
        chk("R6 main level high", test_out, 1);
        main_clk = 1'b0; @(negedge clk);
        chk("R6 main level low", test_out, 0);
    endtask

    task automatic t_ref16();
        tsel = 3'b010;
        do_reset();
        for (int k = 1; k <= 24; k++) begin
            one_edge(0);
            chk("R4 ref divide by 16", test_out, (k / 8) % 2);
        end
    endtask

    task automatic t_main4();
        tsel = 3'b111;
        do_reset();
        for (int k = 1; k <= 8; k++) begin
            one_edge(2);
            chk("R7 main divide by 4", test_out, (k / 2) % 2);
        end
    endtask

    task automatic t_mcnt();
        int got;
        tsel = 3'b011; m_div = 9'd5;
        do_reset();
        count_pulses(0, 4, got);  chk("R5 M=5 no pulse before 5th edge", got, 0);
        count_pulses(0, 1, got);  chk("R5 M=5 pulse at 5th edge", got, 1);
        count_pulses(0, 15, got); chk("R5 M=5 fifteen edges", got, 3);
        m_div = 9'd0;
        count_pulses(0, 6, got);  chk("R5 M=0 pass-through", got, 6);
        m_div = 9'd1;
        count_pulses(0, 3, got);  chk("R5 M=1 pass-through", got, 3);
    endtask

    task automatic t_no_ser();
        int got;
        tsel = 3'b011; m_div = 9'd1;
        do_reset();
        count_pulses(1, 6, got); chk("R10 serial edges ignored", got, 0);
        count_pulses(0, 2, got); chk("R10 reference still counts", got, 2);
    endtask

    task automatic t_bypass();
        int got;
        tsel = 3'b110; m_div = 9'd2; n_code = 2'b11;
        do_reset();
        chk("R8 bypass flag set", bypass, 1);
        count_pulses(1, 10, got); chk("R9 N=11 M=2", got, 5);
        count_pulses(0, 6, got);  chk("R9 reference ignored in bypass", got, 0);
        n_code = 2'b00;
        count_pulses(1, 16, got); chk("R9 N=00 M=2", got, 4);
        n_code = 2'b01; m_div = 9'd1;
        count_pulses(1, 12, got); chk("R9 N=01 M=1", got, 3);
        n_code = 2'b10;
        count_pulses(1, 16, got); chk("R9 N=10 M=1", got, 2);
        tsel = 3'b011; @(negedge clk);
        chk("R8 bypass flag cleared", bypass, 0);
        n_code = 2'b11;
    endtask

    initial begin
        t_reset();
        t_levels();
        t_scan();
        t_main();
        t_ref16();
        t_main4();
        t_mcnt();
        t_no_ser();
        t_bypass();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #600000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule